// File: doc/BRIEF.md
# Overhead Byte Serial Extraction Port

This block takes the overhead bytes that a SONET/SDH framer delivers one at a time, as a parallel byte tagged with its row and column number, and sends them out on four one-bit lanes. The overhead column number decides which lane carries a byte. The column-to-lane stride is four in the two higher-rate modes and three in the lowest-rate mode. In the lowest-rate mode only three lanes carry data, and the fourth lane has its output enable deasserted so that a pad can float.

A single `tick` input acts as the lane bit-clock enable. The system that contains the block generates it at the per-mode lane bit rate: 1.728 MHz for OC-3, 5.184 MHz for OC-12, and 20.736 MHz for OC-48/OC-48c. Lane data and the frame pulse change only on clock edges where `tick` is high. Each lane buffers up to two bytes, so the framer can deliver the next byte while the current one is still being shifted out. A lane that has nothing to send at a byte start outputs zeros and records a sticky underrun.

Top module: `ohx_serial_port`

## Requirements
- R1: `mode` selects the rate: 0 is OC-3, 1 is OC-12, 2 is OC-48, and 3 behaves like 2. A frame holds 216, 648 or 2592 lane bits respectively. `frame_pulse` is high for exactly the tick period of frame bit 0 and low for every other bit.
- R2: The first tick after reset starts frame bit 0. A `sof` pulse makes the next tick start frame bit 0 again. If `sof` coincides with a tick, that same tick restarts the frame.
- R3: In modes 1 to 3, a byte with column c (1-based) goes to lane (c-1) mod 4.
- R4: In mode 0, a byte with column c goes to lane (c-1) mod 3. Lane 3 has `lane_oe[3]` low, its data held at 0, and it never records an underrun.
- R5: Each lane shifts a byte out MSB first, one bit per tick. A new byte starts on every tick whose frame bit index is a multiple of 8. Outputs change only on clock edges where `tick` is high.
- R6: An input byte is ignored if its row is 9 or more, its column is 0, or its column is beyond the mode's column count (9 for OC-3, 36 for OC-12, 144 for OC-48).
- R7: Each lane buffers up to two bytes in arrival order. A byte sent to a lane whose buffer is full is dropped.
- R8: A lane whose buffer is empty at a byte start sends eight zero bits and sets its `underrun` bit. Only reset clears that bit.
- R9: Reset sets `lane_data`, `frame_pulse` and `underrun` to zero, and `lane_oe` shows the lanes that are active in the current mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Lane bit-clock enable |
| mode | input | 2 | Rate select (0 OC-3, 1 OC-12, 2/3 OC-48) |
| sof | input | 1 | Start-of-frame indication from the framer |
| oh_valid | input | 1 | Strobe for the overhead byte |
| oh_byte | input | 8 | Overhead byte value |
| oh_row | input | 4 | Row index, 0 to 8 |
| oh_col | input | 8 | Column index, starting at 1 |
| lane_data | output | 4 | Serial data, one bit per lane |
| lane_oe | output | 4 | Output enable for each lane |
| frame_pulse | output | 1 | Marks frame bit 0 on the lanes |
| underrun | output | 4 | Sticky underrun flag for each lane |

## Verification
A wrong frame counter shows up as a `frame_pulse` that arrives at the wrong tick or stays high too long. It also moves the byte starts, so lane bits are visibly misaligned within eight ticks. A corrupted buffer pointer or fill count shows up at the next byte start on that lane, either as a byte out of order, a dropped byte, or a zero byte with the sticky underrun bit set. The bench therefore compares every lane bit, the enables, the pulse and the underrun flags against its own model on every tick, across all modes and across restarts in the middle of a frame.

// File: rtl/ohx_pkg.sv
package ohx_pkg;
  localparam int unsigned OHX_LANES      = 4;
  localparam int unsigned OHX_BYTE_W     = 8;
  localparam int unsigned OHX_MAX_BITS   = 2592;
  localparam int unsigned OHX_CNT_W      = $clog2(OHX_MAX_BITS);

  typedef enum logic [1:0] {
    OHX_OC3  = 2'd0,
    OHX_OC12 = 2'd1,
    OHX_OC48 = 2'd2,
    OHX_OC48X = 2'd3
  } ohx_mode_e;

  // lane bits per frame
  function automatic logic [OHX_CNT_W-1:0] ohx_frame_bits(ohx_mode_e m);
    case (m)
      OHX_OC3:  return OHX_CNT_W'(216);
      OHX_OC12: return OHX_CNT_W'(648);
      default:  return OHX_CNT_W'(2592);
    endcase
  endfunction

  // overhead columns per row
  function automatic logic [7:0] ohx_col_count(ohx_mode_e m);
    case (m)
      OHX_OC3:  return 8'd9;
      OHX_OC12: return 8'd36;
      default:  return 8'd144;
    endcase
  endfunction

  function automatic logic [2:0] ohx_stride(ohx_mode_e m);
    return (m == OHX_OC3) ? 3'd3 : 3'd4;
  endfunction
endpackage

// File: rtl/ohx_frame_timer.sv
module ohx_frame_timer
  import ohx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      sof,
  input  ohx_mode_e mode,
  output logic      byte_load,
  output logic      frame_pulse
);
  localparam int unsigned CW = OHX_CNT_W;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          fp_q, fp_d;
  logic [CW-1:0] lim;

  assign lim = ohx_frame_bits(mode);

  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    fp_d   = fp_q;
    if (tick) begin
      if (sof || pend_q || (cnt_q >= lim - 1'b1)) cnt_d = '0;
      else                                        cnt_d = cnt_q + 1'b1;
      pend_d = 1'b0;
      fp_d   = (cnt_d == '0);
    end else if (sof) begin
      pend_d = 1'b1;
    end
  end

  assign byte_load   = tick && (cnt_d[2:0] == 3'd0);
  assign frame_pulse = fp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
      fp_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      fp_q   <= fp_d;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q < $past(lim)));
  // R5
  fp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frame_pulse));
  // R2
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sof) |=> (frame_pulse && (cnt_q == '0)));
endmodule

// File: rtl/ohx_lane.sv
module ohx_lane #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          active,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_byte,
  output logic          sdata,
  output logic          underrun
);
  logic [BW-1:0] buf_q [2];
  logic [BW-1:0] buf_d [2];
  logic          rd_q, rd_d, wr_q, wr_d;
  logic [1:0]    fill_q, fill_d;
  logic [BW-1:0] sh_q, sh_d;
  logic          und_q, und_d;
  logic          push, pop;
  logic [BW-1:0] head;

  assign push = wr_en && (fill_q != 2'd2);
  assign pop  = load && active && (fill_q != 2'd0);
  assign head = rd_q ? buf_q[1] : buf_q[0];

  always_comb begin
    buf_d  = buf_q;
    wr_d   = wr_q;
    rd_d   = rd_q;
    sh_d   = sh_q;
    und_d  = und_q;
    if (push) begin
      buf_d[wr_q] = wr_byte;
      wr_d        = ~wr_q;
    end
    if (pop) rd_d = ~rd_q;
    fill_d = fill_q + {1'b0, push} - {1'b0, pop};
    if (load) begin
      sh_d = pop ? head : '0;
      if (active && (fill_q == 2'd0)) und_d = 1'b1;
    end else if (tick) begin
      sh_d = {sh_q[BW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q[0] <= '0;
      buf_q[1] <= '0;
      rd_q     <= 1'b0;
      wr_q     <= 1'b0;
      fill_q   <= 2'd0;
      sh_q     <= '0;
      und_q    <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      fill_q <= fill_d;
      sh_q   <= sh_d;
      und_q  <= und_d;
    end
  end

  assign sdata    = active && sh_q[BW-1];
  assign underrun = und_q;

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= 2'd2);
  // R8
  und_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    und_q |=> und_q);
  // R8
  und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active && (fill_q == 2'd0)) |=> (und_q && (sh_q == '0)));
endmodule

// File: rtl/ohx_serial_port.sv
module ohx_serial_port
  import ohx_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 8,
  parameter int unsigned ROWS  = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [1:0]            mode,
  input  logic                  sof,
  input  logic                  oh_valid,
  input  logic [OHX_BYTE_W-1:0] oh_byte,
  input  logic [ROW_W-1:0]      oh_row,
  input  logic [COL_W-1:0]      oh_col,
  output logic [OHX_LANES-1:0]  lane_data,
  output logic [OHX_LANES-1:0]  lane_oe,
  output logic                  frame_pulse,
  output logic [OHX_LANES-1:0]  underrun
);
  localparam int unsigned SEL_W = $clog2(OHX_LANES);

  ohx_mode_e        md;
  logic             byte_load;
  logic             idx_ok;
  logic [COL_W-1:0] col_m1;
  logic [SEL_W-1:0] sel;

  assign md = ohx_mode_e'(mode);

  ohx_frame_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .sof        (sof),
    .mode       (md),
    .byte_load  (byte_load),
    .frame_pulse(frame_pulse)
  );

  always_comb begin
    col_m1 = oh_col - 1'b1;
    idx_ok = oh_valid && (oh_row < ROW_W'(ROWS)) && (oh_col != '0) &&
             (oh_col <= COL_W'(ohx_col_count(md)));
    if (md == OHX_OC3) sel = SEL_W'(col_m1 % COL_W'(3));
    else               sel = SEL_W'(col_m1 % COL_W'(OHX_LANES));
  end

  for (genvar g = 0; g < OHX_LANES; g++) begin : g_lane
    logic act;
    assign act        = (g < int'(ohx_stride(md)));
    assign lane_oe[g] = act;

    ohx_lane #(.BW(OHX_BYTE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .load    (byte_load),
      .active  (act),
      .wr_en   (idx_ok && (sel == SEL_W'(g))),
      .wr_byte (oh_byte),
      .sdata   (lane_data[g]),
      .underrun(underrun[g])
    );
  end

  // R4
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (md == OHX_OC3) |-> (!lane_oe[3] && !lane_data[3]));
endmodule

// File: tb/ohx_serial_port_tb.sv
module ohx_serial_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, sof, oh_valid;
  logic [1:0] mode;
  logic [7:0] oh_byte;
  logic [3:0] oh_row;
  logic [7:0] oh_col;
  logic [3:0] lane_data, lane_oe, underrun;
  logic       frame_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ohx_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .sof(sof),
    .oh_valid(oh_valid), .oh_byte(oh_byte), .oh_row(oh_row), .oh_col(oh_col),
    .lane_data(lane_data), .lane_oe(lane_oe), .frame_pulse(frame_pulse),
    .underrun(underrun)
  );

  // reference model
  int         m_cnt;
  bit         m_pend;
  logic [7:0] m_q [4][2];
  int         m_n [4];
  logic [7:0] m_sh [4];
  logic [3:0] m_un;

  function automatic int lim_of(int md);
    return (md == 0) ? 216 : (md == 1) ? 648 : 2592;
  endfunction
  function automatic int cols_of(int md);
    return (md == 0) ? 9 : (md == 1) ? 36 : 144;
  endfunction
  function automatic int stride_of(int md);
    return (md == 0) ? 3 : 4;
  endfunction
  function automatic bit act_of(int l, int md);
    return l < stride_of(md);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic model_reset();
    m_cnt = 4095; m_pend = 0; m_un = '0;
    for (int l = 0; l < 4; l++) begin m_n[l] = 0; m_sh[l] = '0; end
  endtask

  task automatic model_tick();
    bit ld;
    if (m_pend || m_cnt >= lim_of(mode) - 1) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    m_pend = 0;
    ld = (m_cnt % 8) == 0;
    for (int l = 0; l < 4; l++) begin
      if (ld) begin
        if (act_of(l, mode) && m_n[l] > 0) begin
          m_sh[l] = m_q[l][0]; m_q[l][0] = m_q[l][1]; m_n[l]--;
        end else begin
          m_sh[l] = '0;
          if (act_of(l, mode)) m_un[l] = 1'b1;
        end
      end else begin
        m_sh[l] = m_sh[l] << 1;
      end
    end
  endtask

  task automatic compare();
    string dt;
    dt = (mode == 0) ? "R4/R5 data" : "R3/R5 data";
    for (int l = 0; l < 4; l++) begin
      logic e;
      e = act_of(l, mode) ? m_sh[l][7] : 1'b0;
      chk(lane_data[l] == e, dt, lane_data[l], e);
    end
    chk(lane_oe == {mode != 0, 3'b111}, "R4 oe", lane_oe, {mode != 0, 3'b111});
    chk(frame_pulse == (m_cnt == 0), "R1/R2 frame_pulse", frame_pulse, m_cnt == 0);
    chk(underrun == m_un, "R8 underrun", underrun, m_un);
  endtask

  task automatic wr(logic [3:0] row, logic [7:0] col, logic [7:0] b);
    int md, l;
    oh_valid = 1'b1; oh_row = row; oh_col = col; oh_byte = b;
    @(posedge clk);
    md = mode;
    if (row < 9 && col != 0 && col <= cols_of(md)) begin
      l = (col - 1) % stride_of(md);
      if (m_n[l] < 2) begin m_q[l][m_n[l]] = b; m_n[l]++; end
    end
    @(negedge clk);
    oh_valid = 1'b0;
  endtask

  task automatic push_lane(int l, logic [7:0] b);
    int s, k;
    s = stride_of(mode);
    k = $urandom % (cols_of(mode) / s);
    wr(4'($urandom % 9), 8'(l + 1 + s * k), b);
  endtask

  // R6 stimulus: out-of-range row or column
  task automatic bad_write();
    int kind;
    kind = $urandom % 3;
    if (kind == 0) wr(4'(9 + $urandom % 7), 8'd1, 8'($urandom));
    else if (kind == 1) wr(4'($urandom % 9), 8'd0, 8'($urandom));
    else wr(4'($urandom % 9), 8'(cols_of(mode) + 1 + $urandom % (255 - cols_of(mode))), 8'($urandom));
  endtask

  task automatic do_tick(bit with_sof);
    tick = 1'b1; sof = with_sof;
    @(posedge clk);
    if (with_sof) m_pend = 1;
    model_tick();
    @(negedge clk);
    tick = 1'b0; sof = 1'b0;
    compare();
  endtask

  task automatic sof_only();
    sof = 1'b1;
    @(posedge clk);
    m_pend = 1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  task automatic run(int n, logic [3:0] mask, bit bad);
    for (int t = 0; t < n; t++) begin
      for (int l = 0; l < 4; l++)
        if (mask[l] && act_of(l, mode) && ($urandom % 4 != 0)) push_lane(l, 8'($urandom));
      if (bad && ($urandom % 8 == 0)) bad_write();
      do_tick(1'b0);
    end
  endtask

  task automatic do_reset(logic [1:0] md);
    rst_n = 1'b0; tick = 0; sof = 0; oh_valid = 0; oh_byte = 0; oh_row = 0; oh_col = 0;
    mode = md;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c03));
    do_reset(2'd0);
    // R9 reset state
    chk(lane_data == 4'b0, "R9 lane_data", lane_data, 0);
    chk(frame_pulse == 1'b0, "R9 frame_pulse", frame_pulse, 0);
    chk(underrun == 4'b0, "R9 underrun", underrun, 0);
    chk(lane_oe == 4'b0111, "R9 lane_oe", lane_oe, 4'b0111);

    // OC-3: prefill, then two frames with random and bad bytes (R1 R4 R5 R6)
    for (int l = 0; l < 3; l++) begin push_lane(l, 8'($urandom)); push_lane(l, 8'($urandom)); end
    run(432, 4'hF, 1'b1);

    // R8: starve lane 1, then refill; the flag stays set
    run(24, 4'b0101, 1'b0);
    chk(underrun[1] == 1'b1, "R8 starved lane", underrun[1], 1);
    run(40, 4'hF, 1'b0);
    chk(underrun[1] == 1'b1, "R8 sticky", underrun[1], 1);

    // R6 directed: a bad byte aimed at an empty lane 0 leaves it empty
    do_reset(2'd0);
    wr(4'd9, 8'd1, 8'hFF);
    wr(4'd0, 8'd0, 8'hFF);
    wr(4'd0, 8'd10, 8'hFF);
    for (int t = 0; t < 8; t++) do_tick(1'b0);
    chk(underrun[0] == 1'b1, "R6 ignored byte", underrun[0], 1);

    // R7 directed: three bytes into lane 2, the third is dropped
    do_reset(2'd1);
    wr(4'd0, 8'd3, 8'hA5);
    wr(4'd1, 8'd7, 8'h3C);
    wr(4'd2, 8'd11, 8'hFF);
    for (int t = 0; t < 24; t++) do_tick(1'b0);
    chk(underrun[2] == 1'b1, "R7 dropped third byte", underrun[2], 1);

    // OC-12 with sof both between ticks and on a tick (R2 R3)
    do_reset(2'd1);
    run(700, 4'hF, 1'b1);
    sof_only();
    run(100, 4'hF, 1'b1);
    do_tick(1'b1);
    chk(frame_pulse == 1'b1, "R2 sof on tick", frame_pulse, 1);
    run(60, 4'hF, 1'b0);

    // OC-48 full frame, then mode 3 (R1 R3)
    mode = 2'd2;
    sof_only();
    run(2650, 4'hF, 1'b1);
    mode = 2'd3;
    run(300, 4'hF, 1'b1);

    // switch back to OC-3 mid frame (R4)
    mode = 2'd0;
    run(250, 4'hF, 1'b1);
    chk(lane_oe[3] == 1'b0, "R4 lane 3 disabled", lane_oe[3], 0);

    summary();
    $finish;
  end
endmodule